// File: doc/BRIEF.md
# Read-Sequence Cleared Packet Counters

This block counts packet and errored-packet events for two traffic directions, transmit and receive. Each direction has a group made of a 32-bit packet counter and a 16-bit error counter. Software reads each group as three 16-bit registers through a plain read strobe with an address. Events arrive as single-cycle pulses on four inputs.

A group freezes as soon as its first register is read, so that software sees one consistent snapshot across all three reads. Events that arrive while the group is frozen go into a shadow accumulator and are not lost. The group is cleared only when its three registers are read strictly as first, second, third. The shadow contents then become the new counts and the group starts counting live again. Any other read order leaves the snapshot frozen and uncleared.

Top module: `pkt_stat_unit`

## Requirements
- R1: Read addresses decode as follows. Address 1 returns the transmit packet count bits 15:0, address 2 returns bits 31:16, and address 3 returns the transmit error count. Addresses 4, 5 and 6 return the same three fields for receive. Addresses 0 and 7 return zero and have no effect on either group.
- R2: `rd_data_o` is combinational and valid in the same cycle as `rd_en_i`. It shows the counter state held at the start of that cycle, and it is zero in any cycle without a read.
- R3: While a group is not frozen, each pulse on a packet or error input raises that counter by one, visible from the next cycle.
- R4: A read of a group's first register freezes that group from that cycle on. Its counters then hold their values until a clear, and events from that cycle onward go to the shadow accumulator.
- R5: A clear happens when the group's third register is read directly after the second, and the second directly after the first, counting only reads of that group. After the clear, each counter equals the events that arrived since the freeze, including the cycle of the third read. The group is then unfrozen.
- R6: If the first register is read again during an attempt, or the second register is read without a directly preceding first, the attempt is broken. A broken attempt ends at the next third-register read without clearing, and the group stays frozen. A later first, second, third sequence clears normally, so 1,2,1,2,3 does not clear.
- R7: Reads of the second or third register while the group is not frozen return live values and do not freeze the group.
- R8: Counters and shadow accumulators saturate at all-ones and never wrap.
- R9: The two groups track their freeze state and read order independently. Reads of one group neither break nor advance the other.
- R10: After reset all counters and shadows are zero and both groups are unfrozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_pkt_i | input | 1 | Transmit packet event pulse |
| tx_err_i | input | 1 | Transmit errored-packet event pulse |
| rx_pkt_i | input | 1 | Receive packet event pulse |
| rx_err_i | input | 1 | Receive errored-packet event pulse |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 16 | Read data, same cycle as strobe |

## Verification
A wrong freeze flag shows up at the next read of either counter field. The field moves between reads that should return a stable snapshot, or it stays stuck after a clear. A wrong read-order state only becomes visible at the following read sequence, as a clear that did not happen or one that should not have happened. For that reason the bench reads back every register after each directed sequence. Loss of shadow events is seen only after a clear, in the first read of the new counts.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned REG_W = 16;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_HAVE1, SEQ_HAVE2, SEQ_BROKEN} seq_e;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (ld_i) cnt_q <= ld_val_i;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !ld_i) |=> cnt_q == MAX); // R8
endmodule

// File: rtl/stat_seq_fsm.sv
module stat_seq_fsm
  import stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic [1:0] sel_i,
  output logic       clr_o
);
  seq_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    clr_o = 1'b0;
    if (rd_i) begin
      unique case (sel_i)
        2'd0: st_d = (st_q == SEQ_IDLE) ? SEQ_HAVE1 : SEQ_BROKEN;
        2'd1: begin
          if (st_q == SEQ_HAVE1) st_d = SEQ_HAVE2;
          else if (st_q != SEQ_IDLE) st_d = SEQ_BROKEN;
        end
        2'd2: begin
          clr_o = (st_q == SEQ_HAVE2);
          st_d  = SEQ_IDLE;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else st_q <= st_d;
  end

  AST_BROKEN_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_BROKEN) |-> !clr_o); // R6
endmodule

// File: rtl/stat_group.sv
module stat_group #(
  parameter int unsigned PKT_W = 32,
  parameter int unsigned ERR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_ev_i,
  input  logic             err_ev_i,
  input  logic             rd_i,
  input  logic [1:0]       sel_i,
  output logic [PKT_W-1:0] pkt_o,
  output logic [ERR_W-1:0] err_o
);
  logic frz_q, first_rd, clr, frz_act;
  logic [PKT_W-1:0] sh_pkt, pkt_ld;
  logic [ERR_W-1:0] sh_err, err_ld;

  assign first_rd = rd_i && (sel_i == 2'd0);
  assign frz_act  = frz_q | first_rd;

  stat_seq_fsm u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rd_i  (rd_i),
    .sel_i (sel_i),
    .clr_o (clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frz_q <= 1'b0;
    else if (clr) frz_q <= 1'b0;
    else if (first_rd) frz_q <= 1'b1;
  end

  // Clear loads shadow plus the event of the clear cycle.
  assign pkt_ld = (pkt_ev_i && sh_pkt != {PKT_W{1'b1}}) ? sh_pkt + 1'b1 : sh_pkt;
  assign err_ld = (err_ev_i && sh_err != {ERR_W{1'b1}}) ? sh_err + 1'b1 : sh_err;

  sat_counter #(.W(PKT_W)) u_sh_pkt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(pkt_ev_i & frz_act & ~clr), .ld_i(clr), .ld_val_i('0), .cnt_o(sh_pkt));
  sat_counter #(.W(ERR_W)) u_sh_err (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(err_ev_i & frz_act & ~clr), .ld_i(clr), .ld_val_i('0), .cnt_o(sh_err));
  sat_counter #(.W(PKT_W)) u_pkt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(pkt_ev_i & ~frz_act), .ld_i(clr), .ld_val_i(pkt_ld), .cnt_o(pkt_o));
  sat_counter #(.W(ERR_W)) u_err (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(err_ev_i & ~frz_act), .ld_i(clr), .ld_val_i(err_ld), .cnt_o(err_o));

  AST_FIRST_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_rd |=> frz_q); // R4
  AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_q && !clr) |=> (pkt_o == $past(pkt_o) && err_o == $past(err_o))); // R4
  AST_CLR_ONLY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |-> frz_q); // R5
  AST_CLR_UNFREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !frz_q); // R5
endmodule

// File: rtl/pkt_stat_unit.sv
module pkt_stat_unit
  import stat_pkg::*;
#(
  parameter int unsigned PKT_W  = 32,
  parameter int unsigned ERR_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_pkt_i,
  input  logic              tx_err_i,
  input  logic              rx_pkt_i,
  input  logic              rx_err_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o
);
  localparam int unsigned NGRP  = 2;
  localparam int unsigned NREG  = 3;
  localparam int unsigned HI_W  = PKT_W - REG_W;

  logic [NGRP-1:0]  pkt_ev, err_ev, grp_hit;
  logic [1:0]       grp_sel [NGRP];
  logic [PKT_W-1:0] pkt_c   [NGRP];
  logic [ERR_W-1:0] err_c   [NGRP];

  assign pkt_ev = {rx_pkt_i, tx_pkt_i};
  assign err_ev = {rx_err_i, tx_err_i};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [NREG-1:0] reg_hit;
    for (genvar k = 0; k < NREG; k++) begin : g_reg
      assign reg_hit[k] = rd_en_i && (rd_addr_i == ADDR_W'(g * NREG + 1 + k));
    end
    assign grp_hit[g] = |reg_hit;
    assign grp_sel[g] = reg_hit[2] ? 2'd2 : (reg_hit[1] ? 2'd1 : 2'd0);

    stat_group #(.PKT_W(PKT_W), .ERR_W(ERR_W)) u_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pkt_ev_i(pkt_ev[g]),
      .err_ev_i(err_ev[g]),
      .rd_i    (grp_hit[g]),
      .sel_i   (grp_sel[g]),
      .pkt_o   (pkt_c[g]),
      .err_o   (err_c[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_hit[g]) begin
        unique case (grp_sel[g])
          2'd0:    rd_data_o = pkt_c[g][REG_W-1:0];
          2'd1:    rd_data_o = REG_W'(pkt_c[g][PKT_W-1:REG_W]);
          default: rd_data_o = REG_W'(err_c[g]);
        endcase
      end
    end
  end

  AST_ONE_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grp_hit)); // R9
  AST_HI_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HI_W <= REG_W)); // R1
endmodule

// File: tb/sim_pkt_stat_unit.sv
`timescale 1ns/1ps
module sim_pkt_stat_unit;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tx_pkt = 0, tx_err = 0, rx_pkt = 0, rx_err = 0, rd_en = 0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;

  always #2.5 clk = ~clk;

  pkt_stat_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_pkt_i(tx_pkt), .tx_err_i(tx_err), .rx_pkt_i(rx_pkt), .rx_err_i(rx_err),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  localparam longint PMAX = 64'hFFFF_FFFF;
  localparam longint EMAX = 64'hFFFF;

  longint m_pkt[2], m_err[2], s_pkt[2], s_err[2];
  int m_frz[2], m_seq[2];  // seq: 0 idle, 1 have first, 2 have second, 3 broken
  int n_run = 0, n_fail = 0;

  function automatic longint sat(longint v, longint mx);
    return (v > mx) ? mx : v;
  endfunction

  function automatic longint expect_data(bit rd, int addr);
    int g, i;
    if (!rd || addr < 1 || addr > 6) return 0;
    g = (addr - 1) / 3;
    i = (addr - 1) % 3;
    if (i == 0) return m_pkt[g] & 64'hFFFF;
    if (i == 1) return (m_pkt[g] >> 16) & 64'hFFFF;
    return m_err[g];
  endfunction

  task automatic step(input bit tp, te, rp, re, rd, input int addr, input string tag);
    longint exp;
    @(negedge clk);
    tx_pkt = tp; tx_err = te; rx_pkt = rp; rx_err = re;
    rd_en = rd; rd_addr = 3'(addr);
    #1;
    exp = expect_data(rd, addr);
    n_run++;
    if (longint'(rd_data) != exp) begin
      n_fail++;
      $display("FAIL %s addr=%0d rd=%0d got=%h exp=%h", tag, addr, rd, rd_data, exp[15:0]);
    end
    for (int g = 0; g < 2; g++) begin
      bit ep, ee;
      int idx;
      bit clr;
      ep = (g == 0) ? tp : rp;
      ee = (g == 0) ? te : re;
      idx = (rd && addr >= 3*g+1 && addr <= 3*g+3) ? addr - 3*g - 1 : -1;
      clr = (idx == 2) && (m_seq[g] == 2);
      if (clr) begin
        m_pkt[g] = sat(s_pkt[g] + ep, PMAX);
        m_err[g] = sat(s_err[g] + ee, EMAX);
        s_pkt[g] = 0; s_err[g] = 0; m_frz[g] = 0;
      end else if (m_frz[g] != 0 || idx == 0) begin
        s_pkt[g] = sat(s_pkt[g] + ep, PMAX);
        s_err[g] = sat(s_err[g] + ee, EMAX);
        m_frz[g] = 1;
      end else begin
        m_pkt[g] = sat(m_pkt[g] + ep, PMAX);
        m_err[g] = sat(m_err[g] + ee, EMAX);
      end
      if (idx == 0) m_seq[g] = (m_seq[g] == 0) ? 1 : 3;
      else if (idx == 1) m_seq[g] = (m_seq[g] == 1) ? 2 : ((m_seq[g] == 0) ? 0 : 3);
      else if (idx == 2) m_seq[g] = 0;
    end
  endtask

  task automatic rd(input int addr, input string tag);
    step(0, 0, 0, 0, 1, addr, tag);
  endtask

  task automatic ev(input bit tp, te, rp, re, input string tag);
    step(tp, te, rp, re, 0, 0, tag);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog got=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    for (int g = 0; g < 2; g++) begin
      m_pkt[g] = 0; m_err[g] = 0; s_pkt[g] = 0; s_err[g] = 0; m_frz[g] = 0; m_seq[g] = 0;
    end
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R10 reset state; R1 full address map
    for (int a = 0; a < 8; a++) rd(a, "R10");
    // R3 live counting; R1 after-freeze reads
    for (int i = 0; i < 10; i++) ev(1, i < 3, i < 7, i[0], "R3");
    rd(2, "R7"); rd(3, "R7"); ev(1, 1, 0, 0, "R7"); rd(3, "R7");
    // R4/R5 in-order clear with events while frozen
    step(1, 0, 0, 0, 1, 1, "R4");
    ev(1, 1, 0, 0, "R4"); rd(1, "R4");
    // that restart of 1 breaks; finish with 3 then redo cleanly
    rd(2, "R6"); rd(3, "R6"); rd(1, "R6");
    step(1, 1, 0, 0, 1, 0, "R1"); rd(7, "R1");
    rd(2, "R5"); step(1, 1, 0, 0, 1, 3, "R5");
    rd(1, "R5"); rd(2, "R5"); rd(3, "R5");
    rd(1, "R5"); rd(2, "R5"); rd(3, "R5");
    // R6 1,2,1,2,3 does not clear
    for (int i = 0; i < 5; i++) ev(1, 1, 1, 1, "R6");
    rd(1, "R6"); rd(2, "R6"); ev(1, 0, 0, 0, "R6"); rd(1, "R6"); rd(2, "R6"); rd(3, "R6");
    rd(2, "R6"); rd(3, "R6");
    rd(1, "R6"); rd(2, "R6"); rd(3, "R6");
    rd(1, "R6"); rd(2, "R6"); rd(3, "R6");
    // R9 interleaved groups both clear
    for (int i = 0; i < 4; i++) ev(0, 1, 1, 0, "R9");
    rd(4, "R9"); rd(1, "R9"); rd(5, "R9"); rd(2, "R9"); step(1, 0, 1, 1, 1, 6, "R9"); rd(3, "R9");
    rd(4, "R9"); rd(5, "R9"); rd(6, "R9"); rd(1, "R9"); rd(2, "R9"); rd(3, "R9");
    // R8 error saturation
    for (int i = 0; i < 65540; i++) ev(1, 1, 0, 0, "R8");
    rd(3, "R8"); rd(2, "R8"); ev(0, 1, 0, 0, "R8"); rd(3, "R8");
    rd(1, "R8"); rd(2, "R8"); rd(3, "R8"); rd(1, "R8");
    // R2 mixed traffic and reads
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      step(r[0], r[1], r[2], r[3], r[4] | r[5], int'(r[8:6]), "R2");
    end
    for (int a = 1; a < 7; a++) rd(a, "R2");

    summary();
    $finish;
  end
endmodule